// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer reached through a small register port: a byte address, write data, write and read strobes, and registered read data. The input clock runs through two dividers in series. The first is an 8-bit linear prescaler. The second is a power-of-two stage that divides by 16, 32, 64 or 128. Each divided-down tick lowers a 16-bit down-counter by one.

A tick that finds the counter at zero is an expiry. On an expiry the counter takes a value from a reload register. The block can also raise a level interrupt, a fixed-length reset request, or both, and each of these has its own enable bit. Software keeps the watchdog quiet by rewriting the count register before the counter runs out. It stops the counter by clearing the run bit.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the control word reads 0x0000_8039 (run set, reset output enabled, division select 3, prescale 0x80). The reload and count registers both read 0x8000. The interrupt and reset-request outputs are low.
- R2: The word address is bus_addr[3:2]: 0 is control, 1 is reload, 2 is count, 3 is interrupt clear. In the control word, bit 0 is the reset enable, bit 2 the interrupt enable, bits [4:3] the division select, bit 5 run, and bits [15:8] the prescale P. All other control bits read 0, so writing all ones reads back 0x0000_FF3D. The clear register reads 0. Read data appears in the cycle after the read strobe.
- R3: While run is set, a tick occurs every (P+1)·(16·2^sel) clocks. Each tick lowers a nonzero counter by exactly one.
- R4: A tick that finds the counter at zero loads the counter from the reload register.
- R5: When the interrupt enable is set, an expiry raises the interrupt. It stays high until a write to the clear register with data bit 0 equal to 1. A clear write with bit 0 equal to 0 has no effect.
- R6: When the reset enable is set, an expiry drives the reset request high for exactly 128 clocks. With the reset enable clear, an expiry produces no reset request.
- R7: A write to the count register loads the counter directly. If it lands on the same edge as a tick, the write wins.
- R8: With run clear, the counter holds its value and no expiry occurs.
- R9: Any write to the control register restarts both divider stages from zero. The first tick then comes a full period after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Level interrupt on expiry |
| rst_req_o | output | 1 | Reset request pulse on expiry |

## Verification
The assertions assume that a strobe is held for a single clock and that reads and writes are never issued together. They also assume that a new expiry never arrives while a reset pulse is still running, because a retrigger would legally stretch the pulse. The bench drives exactly one bus operation per clock and keeps the reset-pulse scenario's reload value large enough that no second expiry falls inside the pulse. It always stops the counter before loading new reload and count values, so every expiry edge is known ahead of time.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 32;
  localparam int PRE_W  = 8;
  localparam int SEL_W  = 2;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_COUNT  = 2'd2,
    REG_ICLR   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             run;
    logic [SEL_W-1:0] div_sel;
    logic             irq_en;
    logic             rst_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{pre: 8'h80, run: 1'b1, div_sel: 2'd3,
                                 irq_en: 1'b0, rst_en: 1'b1};

  function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[15:8]  = c.pre;
    w[5]     = c.run;
    w[4:3]   = c.div_sel;
    w[2]     = c.irq_en;
    w[0]     = c.rst_en;
    return w;
  endfunction

  function automatic ctrl_t ctrl_unpack(logic [DATA_W-1:0] w);
    ctrl_t c;
    c.pre     = w[15:8];
    c.run     = w[5];
    c.div_sel = w[4:3];
    c.irq_en  = w[2];
    c.rst_en  = w[0];
    return c;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RELOAD_RST = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              ctrl_wr,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_wdata,
  output logic              irq_clr
);
  reg_sel_e          sel;
  ctrl_t             ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  reload_q, reload_d;
  logic [DATA_W-1:0] rdata_q, rdata_d, rd_word;

  always_comb begin
    sel       = reg_sel_e'(addr[3:2]);
    ctrl_wr   = wr_en && (sel == REG_CTRL);
    cnt_wr    = wr_en && (sel == REG_COUNT);
    irq_clr   = wr_en && (sel == REG_ICLR) && wdata[0];
    cnt_wdata = wdata[CNT_W-1:0];
    ctrl_d    = ctrl_q;
    reload_d  = reload_q;
    if (ctrl_wr) ctrl_d = ctrl_unpack(wdata);
    if (wr_en && (sel == REG_RELOAD)) reload_d = wdata[CNT_W-1:0];
    case (sel)
      REG_CTRL:   rd_word = ctrl_pack(ctrl_q);
      REG_RELOAD: rd_word = DATA_W'(reload_q);
      REG_COUNT:  rd_word = DATA_W'(cnt_val);
      default:    rd_word = '0;
    endcase
    rdata_d = rd_en ? rd_word : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      reload_q <= CNT_W'(RELOAD_RST);
      rdata_q  <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
      rdata_q  <= rdata_d;
    end
  end

  assign ctrl   = ctrl_q;
  assign reload = reload_q;
  assign rdata  = rdata_q;

  p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_pack(ctrl) == ($past(wdata) & 32'h0000_FF3D));
endmodule

// File: rtl/wdt_tick.sv
module wdt_tick #(
  parameter int PRE_W    = 8,
  parameter int SEL_W    = 2,
  parameter int BASE_LOG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             restart,
  output logic             tick
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int DIV_W = BASE_LOG + NSEL - 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] last_tab [NSEL];
  logic             pre_wrap, div_wrap;

  for (genvar g = 0; g < NSEL; g++) begin : g_last
    assign last_tab[g] = DIV_W'((1 << (BASE_LOG + g)) - 1);
  end

  always_comb begin
    pre_wrap = (pre_q == pre);
    div_wrap = (div_q == last_tab[div_sel]);
    tick     = run && pre_wrap && div_wrap && !restart;
    pre_d    = pre_q;
    div_d    = div_q;
    if (restart) begin
      pre_d = '0;
      div_d = '0;
    end else if (run) begin
      if (pre_wrap) begin
        pre_d = '0;
        div_d = div_wrap ? '0 : div_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_d;
      div_q <= div_d;
    end
  end

  p_phase_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CNT_W     = 16,
  parameter int RST_PULSE = 128,
  parameter int INIT      = 16'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] reload,
  input  logic             irq_en,
  input  logic             rst_en,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             irq,
  output logic             rst_req
);
  localparam int RT_W = $clog2(RST_PULSE + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic [RT_W-1:0]  rt_q, rt_d;
  logic             expire;

  always_comb begin
    expire = tick && !cnt_wr && (cnt_q == '0);
    cnt_d  = cnt_q;
    if (cnt_wr)                 cnt_d = cnt_wdata;
    else if (tick && cnt_q != 0) cnt_d = cnt_q - 1'b1;
    else if (tick)               cnt_d = reload;
    irq_d = irq_q;
    if (expire && irq_en) irq_d = 1'b1;
    else if (irq_clr)     irq_d = 1'b0;
    rt_d = rt_q;
    if (expire && rst_en) rt_d = RT_W'(RST_PULSE);
    else if (rt_q != '0)  rt_d = rt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(INIT);
      irq_q <= 1'b0;
      rt_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
      rt_q  <= rt_d;
    end
  end

  assign cnt     = cnt_q;
  assign irq     = irq_q;
  assign rst_req = (rt_q != '0);

  // Checker counter: length of the current reset-request pulse.
  logic [15:0] hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             hi_len <= '0;
    else if (!rst_req)      hi_len <= '0;
    else if (hi_len != '1)  hi_len <= hi_len + 1'b1;
  end

  p_dec_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt != 0) |=> cnt == $past(cnt) - 1'b1);
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt == 0) |=> cnt == $past(reload));
  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  p_rst_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> hi_len >= 16'(RST_PULSE));
  p_direct_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(cnt_wdata));
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BASE_LOG  = 4,
  parameter int RST_PULSE = 128,
  parameter int INIT_VAL  = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [1:0]       rst_sync;
  logic             rst_n_i;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, cnt, cnt_wdata;
  logic             ctrl_wr, cnt_wr, irq_clr, tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  wdt_regs #(.CNT_W(CNT_W), .RELOAD_RST(INIT_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .addr(bus_addr), .wr_en(bus_wr),
    .rd_en(bus_rd), .wdata(bus_wdata), .cnt_val(cnt), .rdata(bus_rdata),
    .ctrl(ctrl), .reload(reload), .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .irq_clr(irq_clr)
  );

  wdt_tick #(.PRE_W(PRE_W), .SEL_W(SEL_W), .BASE_LOG(BASE_LOG)) u_tick (
    .clk(clk), .rst_n(rst_n_i), .run(ctrl.run), .pre(ctrl.pre),
    .div_sel(ctrl.div_sel), .restart(ctrl_wr), .tick(tick)
  );

  wdt_count #(.CNT_W(CNT_W), .RST_PULSE(RST_PULSE), .INIT(INIT_VAL)) u_count (
    .clk(clk), .rst_n(rst_n_i), .tick(tick), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .reload(reload), .irq_en(ctrl.irq_en),
    .rst_en(ctrl.rst_en), .irq_clr(irq_clr), .cnt(cnt), .irq(irq_o),
    .rst_req(rst_req_o)
  );

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!ctrl.run && !cnt_wr) |=> $stable(cnt));
  p_no_expiry_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!ctrl.run && !irq_o) |=> !irq_o);
endmodule

// File: tb/tb_tick_watchdog.sv
module tb_tick_watchdog;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o, rst_req_o;
  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  tick_watchdog dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  localparam logic [3:0] A_CTRL = 4'h0, A_RLD = 4'h4, A_CNT = 4'h8, A_CLR = 4'hC;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic prep(input logic [15:0] rld, input logic [15:0] cnt);
    wr(A_CTRL, 32'h0);
    wr(A_CLR, 32'h1);
    wr(A_RLD, {16'h0, rld});
    wr(A_CNT, {16'h0, cnt});
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq low", {31'h0, irq_o}, 32'h0);
    chk("R1 rst_req low", {31'h0, rst_req_o}, 32'h0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0000_8039);
    rd(A_RLD, v);  chk("R1 reload", v, 32'h8000);
    rd(A_CNT, v);  chk("R1 count", v, 32'h8000);
  endtask

  task automatic t_readback;
    logic [31:0] v;
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R2 ctrl mask", v, 32'h0000_FF3D);
    rd(A_CLR, v);  chk("R2 clear reads zero", v, 32'h0);
    wr(A_CTRL, 32'h0);
    wr(A_RLD, 32'h1234_ABCD);
    rd(A_RLD, v);  chk("R2 reload width", v, 32'hABCD);
  endtask

  task automatic t_expire_irq;
    logic [31:0] v;
    prep(16'd5, 16'd2);
    wr(A_CTRL, 32'h24);             // E0: run + irq enable, P=0, /16
    step(20);
    rd(A_CNT, v); chk("R3 one tick decrement", v, 32'd1);
    step(26);
    chk("R3 no expiry before third tick", {31'h0, irq_o}, 32'h0);
    step(1);
    chk("R5 irq on expiry", {31'h0, irq_o}, 32'h1);
    chk("R6 no reset when disabled", {31'h0, rst_req_o}, 32'h0);
    rd(A_CNT, v); chk("R4 reload on expiry", v, 32'd5);
    step(10);
    chk("R5 irq held", {31'h0, irq_o}, 32'h1);
    wr(A_CLR, 32'h0);
    chk("R5 clear with bit0=0 ignored", {31'h0, irq_o}, 32'h1);
    wr(A_CLR, 32'h1);
    chk("R5 clear with bit0=1", {31'h0, irq_o}, 32'h0);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_prescale;
    prep(16'd9, 16'd3);
    wr(A_CTRL, 32'h22C);            // P=2, /32 -> 96 clocks per tick
    step(383);
    chk("R3 prescaled period early", {31'h0, irq_o}, 32'h0);
    step(1);
    chk("R3 prescaled period expiry", {31'h0, irq_o}, 32'h1);
    wr(A_CTRL, 32'h0);
    wr(A_CLR, 32'h1);
  endtask

  task automatic t_reset_pulse;
    prep(16'h100, 16'd0);
    wr(A_CTRL, 32'h21);             // run + reset enable
    step(15);
    chk("R6 pulse not yet", {31'h0, rst_req_o}, 32'h0);
    step(1);
    chk("R6 pulse start", {31'h0, rst_req_o}, 32'h1);
    chk("R5 no irq when disabled", {31'h0, irq_o}, 32'h0);
    step(127);
    chk("R6 pulse last cycle", {31'h0, rst_req_o}, 32'h1);
    step(1);
    chk("R6 pulse ended", {31'h0, rst_req_o}, 32'h0);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_refresh;
    logic [31:0] v;
    prep(16'd5, 16'd2);
    wr(A_CTRL, 32'h24);             // E0
    step(40);
    wr(A_CNT, 32'd3);               // edge E0+41
    step(9);
    chk("R7 refresh prevents expiry", {31'h0, irq_o}, 32'h0);
    step(45);
    chk("R7 refreshed not yet expired", {31'h0, irq_o}, 32'h0);
    step(1);
    chk("R7 refreshed expiry", {31'h0, irq_o}, 32'h1);
    prep(16'd5, 16'd9);
    wr(A_CTRL, 32'h20);             // E0
    step(15);
    wr(A_CNT, 32'd7);               // on tick edge E0+16
    rd(A_CNT, v); chk("R7 write wins over tick", v, 32'd7);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_frozen;
    logic [31:0] v;
    prep(16'd5, 16'd4);
    step(100);
    rd(A_CNT, v); chk("R8 count frozen", v, 32'd4);
    wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h04);             // irq enable, run clear
    step(100);
    chk("R8 no expiry when stopped", {31'h0, irq_o}, 32'h0);
    rd(A_CNT, v); chk("R8 zero count held", v, 32'd0);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    prep(16'd5, 16'd5);
    wr(A_CTRL, 32'h20);             // E0
    step(10);
    wr(A_CTRL, 32'h20);             // E1, phase restart
    step(5);
    rd(A_CNT, v); chk("R9 no tick at old phase", v, 32'd5);
    step(10);
    rd(A_CNT, v); chk("R9 tick one period after write", v, 32'd4);
    wr(A_CTRL, 32'h0);
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; fails++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_readback();
    t_expire_irq();
    t_prescale();
    t_reset_pulse();
    t_refresh();
    t_frozen();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule